// File: doc/BRIEF.md
# Interrupt Entry and Wait Sequencer

This block is the control sequencer that an 8-bit processor core uses to enter interrupt and trap handlers. At each instruction boundary the core pulses `insn_start` and presents the class of the instruction it is about to run, along with its condition-code byte. The sequencer first looks for a pending hardware request. There are three hardware sources: an edge-triggered non-maskable line, a fast request line and a normal request line. If a request is pending it starts that entry. If none is pending, it acts on the instruction class, which may be one of three software traps or one of two wait instructions.

For each entry the sequencer chooses between a full and a partial register save. It records that choice in the entire-state flag of the condition codes, asks an external stack engine to push the registers, and raises the mask bits the source calls for. It then waits a fixed delay and reads the 16-bit handler address from the vector area as two bytes. When the entry completes it hands the new program counter and condition codes back to the core with a load strobe.

The synchronise-wait instruction stalls until any request line is active, and then resumes at the next instruction. The mask-and-wait instruction first narrows the condition codes and stacks everything. It then stalls until an enabled request arrives and goes straight to the vector fetch.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rst_n` is low, and after its release until `insn_start` is pulsed, `push_req`, `bus_rd`, `pc_load`, `cc_load`, `resume` and `busy` are 0.
- R2: Condition-code bits are E=bit 7, F=bit 6 and I=bit 4. At `insn_start` the sources are taken in this order: a latched non-maskable edge first, then the fast line if F=0, then the normal line if I=0. A pending request is taken instead of the presented instruction.
- R3: The non-maskable line is latched on its rising edge. The latch is cleared when its entry begins. The entry sets E, pushes the full set, sets I and F, and uses vector 0xFFFC.
- R4: A fast entry with `fast_full_cfg`=0 clears E and pushes the partial set (`push_full`=0). With `fast_full_cfg`=1 it sets E and pushes the full set. Either way it sets I and F and uses vector 0xFFF6.
- R5: A normal entry sets E, pushes the full set, sets I, leaves F unchanged, and uses vector 0xFFF8.
- R6: `insn_op` codes 1, 2 and 3 are traps with vectors 0xFFFA, 0xFFF4 and 0xFFF2. All three set E and push the full set. Code 1 also sets I and F; codes 2 and 3 leave I and F unchanged.
- R7: After the push handshake, exactly `VEC_DELAY` (default 4) cycles pass with no bus read. The block then reads the vector address and vector+1 on consecutive cycles. On the next cycle it pulses `pc_load` and `cc_load`, with `pc_out` = {first byte, second byte}.
- R8: `insn_op` code 4 (synchronise-wait) makes no push and no read. It stalls until the non-maskable latch, the fast line or the normal line is active, whatever the mask bits are, and then pulses `resume`.
- R9: `insn_op` code 5 (mask-and-wait) sets the condition codes to (`cc_in` AND `mask_imm`) with E set and pushes the full set once. It then stalls while no source is enabled under those narrowed condition codes.
- R10: On leaving mask-and-wait, the block sets I, and sets F unless the winner is the normal line. It does not push again. It fetches the winner's vector and clears the non-maskable latch if that source won.
- R11: While `push_req` is high, E in `cc_out` equals `push_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_line | input | 1 | Non-maskable request, rising-edge sensitive |
| fast_line | input | 1 | Fast request, level sensitive |
| norm_line | input | 1 | Normal request, level sensitive |
| fast_full_cfg | input | 1 | Fast entry saves the full register set |
| insn_start | input | 1 | Instruction boundary strobe |
| insn_op | input | 3 | Instruction class (0 none, 1-3 traps, 4 sync-wait, 5 mask-and-wait) |
| mask_imm | input | 8 | Immediate mask for mask-and-wait |
| cc_in | input | 8 | Current condition-code byte |
| push_req | output | 1 | Stack push request, held until acknowledged |
| push_full | output | 1 | Push the full set (1) or the partial set (0) |
| push_ack | input | 1 | Stack engine finished the push |
| bus_rd | output | 1 | Vector byte read strobe |
| bus_addr | output | 16 | Vector byte address |
| bus_rdata | input | 8 | Read data, valid in the cycle of `bus_rd` |
| pc_out | output | 16 | New program counter |
| pc_load | output | 1 | Load `pc_out` into the core |
| cc_out | output | 8 | New condition codes (also the value seen by the stack engine) |
| cc_load | output | 1 | Load `cc_out` into the core |
| resume | output | 1 | Wait ended without an entry; continue with the next instruction |
| busy | output | 1 | Sequence in progress |

## Verification
The assertions check, on every cycle, the properties that can be read at the ports alone. They cover the agreement between the stack push width and the E flag, a held push request, and that vector reads fall in the vector area as a consecutive address pair. They also check that a program-counter load follows the second read, and that a wait exit without entry touches neither stack nor bus. Other behaviour depends on history, so only the bench scenarios show it. This covers the choice of winner when several sources compete, the exact mask bits and vector for each source, and the four-cycle gap after the push. It also covers that mask-and-wait ignores a request it has just masked and pushes only once, and that the non-maskable latch is consumed by the entry that takes it.

// File: rtl/irq_seq_pkg.sv
// Shared types and constants for the interrupt entry sequencer.
// Assumes the condition-code layout E=7, F=6, I=4.
package irq_seq_pkg;

    localparam int unsigned CC_E = 7;
    localparam int unsigned CC_F = 6;
    localparam int unsigned CC_I = 4;
    localparam logic [7:0] CC_EB = 8'd1 << CC_E;
    localparam logic [7:0] CC_FB = 8'd1 << CC_F;
    localparam logic [7:0] CC_IB = 8'd1 << CC_I;

    localparam logic [15:0] VEC_NMI   = 16'hFFFC;
    localparam logic [15:0] VEC_FAST  = 16'hFFF6;
    localparam logic [15:0] VEC_NORM  = 16'hFFF8;
    localparam logic [15:0] VEC_TRAP1 = 16'hFFFA;
    localparam logic [15:0] VEC_TRAP2 = 16'hFFF4;
    localparam logic [15:0] VEC_TRAP3 = 16'hFFF2;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_TRAP1 = 3'd1,
        OP_TRAP2 = 3'd2,
        OP_TRAP3 = 3'd3,
        OP_SYNC  = 3'd4,
        OP_MWAIT = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NMI  = 2'd1,
        SRC_FAST = 2'd2,
        SRC_NORM = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_PUSH   = 3'd1,
        S_DELAY  = 3'd2,
        S_RD_HI  = 3'd3,
        S_RD_LO  = 3'd4,
        S_FINISH = 3'd5,
        S_SYNC   = 3'd6,
        S_MWAIT  = 3'd7
    } state_e;

    // Vector address of a hardware source.
    function automatic logic [15:0] hw_vector(src_e s);
        case (s)
            SRC_NMI:  return VEC_NMI;
            SRC_FAST: return VEC_FAST;
            default:  return VEC_NORM;
        endcase
    endfunction

endpackage

// File: rtl/irq_nmi_latch.sv
// Rising-edge detector and pending latch for the non-maskable line.
// Assumes the line is already synchronous to clk. A new edge wins over a
// clear in the same cycle, so no edge is lost.
module irq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic clr,
    output logic pend
);

    logic prev_q;

    // Track the previous line level and hold the pending flag until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            prev_q <= line;
            pend   <= (pend & ~clr) | (line & ~prev_q);
        end
    end

endmodule

// File: rtl/irq_prio_arb.sv
// Fixed-priority pick among the three hardware sources under the mask bits
// of a given condition-code byte. Purely combinational.
module irq_prio_arb
    import irq_seq_pkg::*;
(
    input  logic       nmi_pend,
    input  logic       fast_req,
    input  logic       norm_req,
    input  logic [7:0] cc,
    output src_e       src
);

    // Non-maskable first, then fast (F clear), then normal (I clear).
    always_comb begin
        if (nmi_pend)                    src = SRC_NMI;
        else if (fast_req && !cc[CC_F])  src = SRC_FAST;
        else if (norm_req && !cc[CC_I])  src = SRC_NORM;
        else                             src = SRC_NONE;
    end

endmodule

// File: rtl/irq_delay_timer.sv
// Counts the cycles spent in the pre-fetch delay. done is high in the last
// cycle of a run of DELAY cycles. Assumes DELAY >= 1 and that run drops
// once done has been seen.
module irq_delay_timer #(
    parameter int unsigned DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int unsigned CW = (DELAY > 1) ? $clog2(DELAY) : 1;
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

    logic [CW-1:0] cnt_q;

    // Count while running, restart from zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == LAST);

endmodule

// File: rtl/irq_entry_seq.sv
// Interrupt entry and wait sequencer.
// At an instruction boundary it takes a pending hardware request, or else
// runs a trap or wait instruction. For an entry it sets the save-set flag
// and the masks, requests a stack push, waits VEC_DELAY cycles and fetches
// the handler address as two bytes. Assumes bus_rdata is valid in the same
// cycle as bus_rd, and that insn_start is only pulsed while busy is low.
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int unsigned VEC_DELAY = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        nmi_line,
    input  logic        fast_line,
    input  logic        norm_line,
    input  logic        fast_full_cfg,
    input  logic        insn_start,
    input  logic [2:0]  insn_op,
    input  logic [7:0]  mask_imm,
    input  logic [7:0]  cc_in,
    output logic        push_req,
    output logic        push_full,
    input  logic        push_ack,
    output logic        bus_rd,
    output logic [15:0] bus_addr,
    input  logic [7:0]  bus_rdata,
    output logic [15:0] pc_out,
    output logic        pc_load,
    output logic [7:0]  cc_out,
    output logic        cc_load,
    output logic        resume,
    output logic        busy
);

    state_e      state;
    logic [7:0]  cc_q;
    logic [7:0]  set_q;
    logic [15:0] vec_q;
    logic [7:0]  hi_q;
    logic [15:0] pc_q;
    logic        full_q;
    logic        mw_q;
    logic        vec_mode_q;

    logic        nmi_pend;
    logic        nmi_clr;
    logic [7:0]  arb_cc;
    src_e        arb_src;
    logic        tmr_done;
    op_e         op;

    assign op = op_e'(insn_op);

    // The arbiter judges masks on the live CC, or on the narrowed CC while in mask-and-wait.
    assign arb_cc = (state == S_MWAIT) ? cc_q : cc_in;

    // The non-maskable latch is consumed when its entry starts.
    assign nmi_clr = (arb_src == SRC_NMI) &&
                     (((state == S_IDLE) && insn_start) || (state == S_MWAIT));

    irq_nmi_latch u_nmi (
        .clk   (clk),
        .rst_n (rst_n),
        .line  (nmi_line),
        .clr   (nmi_clr),
        .pend  (nmi_pend)
    );

    irq_prio_arb u_arb (
        .nmi_pend (nmi_pend),
        .fast_req (fast_line),
        .norm_req (norm_line),
        .cc       (arb_cc),
        .src      (arb_src)
    );

    irq_delay_timer #(.DELAY(VEC_DELAY)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == S_DELAY),
        .done  (tmr_done)
    );

    // Main sequencing: entry choice, push handshake, wait states, vector fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            cc_q       <= '0;
            set_q      <= '0;
            vec_q      <= '0;
            hi_q       <= '0;
            pc_q       <= '0;
            full_q     <= 1'b0;
            mw_q       <= 1'b0;
            vec_mode_q <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (insn_start) begin
                        mw_q <= 1'b0;
                        if (arb_src != SRC_NONE) begin
                            vec_q <= hw_vector(arb_src);
                            state <= S_PUSH;
                            case (arb_src)
                                SRC_FAST: begin
                                    full_q <= fast_full_cfg;
                                    cc_q   <= fast_full_cfg ? (cc_in | CC_EB) : (cc_in & ~CC_EB);
                                    set_q  <= CC_IB | CC_FB;
                                end
                                SRC_NORM: begin
                                    full_q <= 1'b1;
                                    cc_q   <= cc_in | CC_EB;
                                    set_q  <= CC_IB;
                                end
                                default: begin
                                    full_q <= 1'b1;
                                    cc_q   <= cc_in | CC_EB;
                                    set_q  <= CC_IB | CC_FB;
                                end
                            endcase
                        end else begin
                            case (op)
                                OP_TRAP1: begin
                                    vec_q  <= VEC_TRAP1;
                                    full_q <= 1'b1;
                                    cc_q   <= cc_in | CC_EB;
                                    set_q  <= CC_IB | CC_FB;
                                    state  <= S_PUSH;
                                end
                                OP_TRAP2, OP_TRAP3: begin
                                    vec_q  <= (op == OP_TRAP2) ? VEC_TRAP2 : VEC_TRAP3;
                                    full_q <= 1'b1;
                                    cc_q   <= cc_in | CC_EB;
                                    set_q  <= '0;
                                    state  <= S_PUSH;
                                end
                                OP_SYNC: begin
                                    state <= S_SYNC;
                                end
                                OP_MWAIT: begin
                                    full_q <= 1'b1;
                                    cc_q   <= (cc_in & mask_imm) | CC_EB;
                                    set_q  <= '0;
                                    mw_q   <= 1'b1;
                                    state  <= S_PUSH;
                                end
                                default: ;
                            endcase
                        end
                    end
                end
                S_PUSH: begin
                    if (push_ack) begin
                        if (mw_q) begin
                            state <= S_MWAIT;
                        end else begin
                            cc_q  <= cc_q | set_q;
                            state <= S_DELAY;
                        end
                    end
                end
                S_MWAIT: begin
                    if (arb_src != SRC_NONE) begin
                        cc_q  <= cc_q | CC_IB | ((arb_src == SRC_NORM) ? 8'h00 : CC_FB);
                        vec_q <= hw_vector(arb_src);
                        state <= S_DELAY;
                    end
                end
                S_DELAY: begin
                    if (tmr_done) state <= S_RD_HI;
                end
                S_RD_HI: begin
                    hi_q  <= bus_rdata;
                    state <= S_RD_LO;
                end
                S_RD_LO: begin
                    pc_q       <= {hi_q, bus_rdata};
                    vec_mode_q <= 1'b1;
                    state      <= S_FINISH;
                end
                S_SYNC: begin
                    if (nmi_pend || fast_line || norm_line) begin
                        vec_mode_q <= 1'b0;
                        state      <= S_FINISH;
                    end
                end
                default: begin
                    state <= S_IDLE;
                end
            endcase
        end
    end

    assign push_req  = (state == S_PUSH);
    assign push_full = full_q;
    assign bus_rd    = (state == S_RD_HI) || (state == S_RD_LO);
    assign bus_addr  = vec_q + {15'd0, (state == S_RD_LO)};
    assign pc_out    = pc_q;
    assign pc_load   = (state == S_FINISH) && vec_mode_q;
    assign cc_load   = (state == S_FINISH) && vec_mode_q;
    assign resume    = (state == S_FINISH) && !vec_mode_q;
    assign cc_out    = cc_q;
    assign busy      = (state != S_IDLE);

endmodule

// File: rtl/irq_seq_chk.sv
// Port-level property checker for irq_entry_seq, attached by bind.
// Assumes nothing beyond the top-level ports.
module irq_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        push_req,
    input logic        push_full,
    input logic        push_ack,
    input logic        bus_rd,
    input logic [15:0] bus_addr,
    input logic        pc_load,
    input logic [7:0]  cc_out,
    input logic        resume
);

    assert_full_sets_e_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && push_full) |-> cc_out[7]);

    assert_partial_clears_e_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !push_full) |-> !cc_out[7]);

    assert_push_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !push_ack) |=> push_req);

    assert_no_read_in_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> !bus_rd);

    assert_gap_after_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(push_req) |-> !bus_rd);

    assert_vec_area_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (bus_addr[15:4] == 12'hFFF));

    assert_vec_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && $past(bus_rd)) |-> (bus_addr == 16'($past(bus_addr) + 16'd1)));

    assert_load_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> ($past(bus_rd) && !bus_rd));

    assert_resume_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> (!pc_load && !push_req && !bus_rd));

endmodule

bind irq_entry_seq irq_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (push_req),
    .push_full (push_full),
    .push_ack  (push_ack),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .pc_load   (pc_load),
    .cc_out    (cc_out),
    .resume    (resume)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_line = 1'b0, fast_line = 1'b0, norm_line = 1'b0;
    logic        fast_full_cfg = 1'b0, insn_start = 1'b0;
    logic [2:0]  insn_op = 3'd0;
    logic [7:0]  mask_imm = 8'hFF, cc_in = 8'h00;
    logic        push_req, push_full, bus_rd, pc_load, cc_load, resume, busy;
    logic        push_ack = 1'b0;
    logic [15:0] bus_addr, pc_out;
    logic [7:0]  bus_rdata, cc_out;

    int n_chk = 0, n_err = 0, cyc = 0;
    int pushes = 0, rd_cnt = 0, gap = 0, gap_seen = -1;
    bit armed = 0, last_full = 0, last_e = 0, exp_nmi = 0;
    bit got_vec, got_ok;
    logic [15:0] cap_pc;
    logic [7:0]  cap_cc;

    always #4 clk = ~clk;

    function automatic logic [7:0] mem_byte(logic [15:0] a);
        return a[7:0] ^ 8'h3C ^ {a[3:0], a[7:4]};
    endfunction

    assign bus_rdata = mem_byte(bus_addr);

    irq_entry_seq i_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .nmi_line(nmi_line), .fast_line(fast_line),
        .norm_line(norm_line), .fast_full_cfg(fast_full_cfg), .insn_start(insn_start),
        .insn_op(insn_op), .mask_imm(mask_imm), .cc_in(cc_in), .push_req(push_req),
        .push_full(push_full), .push_ack(push_ack), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_rdata(bus_rdata), .pc_out(pc_out), .pc_load(pc_load), .cc_out(cc_out),
        .cc_load(cc_load), .resume(resume), .busy(busy)
    );

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Stack engine model, handshake and read monitor, watchdog.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
        push_ack = push_req && ($urandom % 3 != 0);
        if (push_ack) begin
            pushes++; last_full = push_full; last_e = cc_out[7];
            armed = 1; gap = 0;
        end else if (armed) begin
            if (bus_rd) begin gap_seen = gap; armed = 0; end
            else gap++;
        end
        if (bus_rd) rd_cnt++;
    end

    task automatic start_op(input logic [2:0] op, input logic [7:0] cc, input logic [7:0] imm,
                            input bit cfg, input bit f, input bit n);
        pushes = 0; rd_cnt = 0; gap_seen = -1; armed = 0;
        @(negedge clk);
        cc_in = cc; insn_op = op; mask_imm = imm; fast_full_cfg = cfg;
        fast_line = f; norm_line = n; insn_start = 1'b1;
        @(negedge clk);
        insn_start = 1'b0;
    endtask

    task automatic wait_done();
        got_vec = 0; got_ok = 0;
        for (int i = 0; i < 400; i++) begin
            if (pc_load) begin got_vec = 1; got_ok = 1; cap_pc = pc_out; cap_cc = cc_out; break; end
            if (resume) begin got_ok = 1; break; end
            @(negedge clk);
        end
        #1;
        fast_line = 1'b0; norm_line = 1'b0;
    endtask

    task automatic nmi_pulse();
        @(negedge clk); nmi_line = 1'b1;
        @(negedge clk); nmi_line = 1'b0;
        exp_nmi = 1;
    endtask

    // Expected outcome from the requirements (R2..R6, R8).
    task automatic predict(input bit np, input bit f, input bit n, input bit cfg,
                           input logic [2:0] op, input logic [7:0] cc,
                           output bit e_vec, output logic [15:0] e_pc, output logic [7:0] e_cc,
                           output bit e_full, output bit e_nmi, output string tag);
        logic [15:0] v;
        e_vec = 1; e_full = 1; e_nmi = 0; v = 16'h0; e_cc = cc;
        if (np) begin v = 16'hFFFC; e_cc = cc | 8'hD0; e_nmi = 1; tag = "R2 R3"; end
        else if (f && !cc[6]) begin
            v = 16'hFFF6; e_full = cfg; e_cc = (cfg ? (cc | 8'h80) : (cc & 8'h7F)) | 8'h50; tag = "R2 R4";
        end else if (n && !cc[4]) begin v = 16'hFFF8; e_cc = cc | 8'h90; tag = "R2 R5"; end
        else if (op == 3'd1) begin v = 16'hFFFA; e_cc = cc | 8'hD0; tag = "R6"; end
        else if (op == 3'd2) begin v = 16'hFFF4; e_cc = cc | 8'h80; tag = "R6"; end
        else if (op == 3'd3) begin v = 16'hFFF2; e_cc = cc | 8'h80; tag = "R6"; end
        else begin e_vec = 0; tag = "R8"; end
        e_pc = {mem_byte(v), mem_byte(v + 16'd1)};
    endtask

    task automatic check_vec(input string tag, input logic [15:0] e_pc, input logic [7:0] e_cc,
                             input bit e_full, input bit check_gap);
        chk_eq({tag, " done"}, {31'd0, got_ok}, 32'd1);
        chk_eq({tag, " vector entry"}, {31'd0, got_vec}, 32'd1);
        chk_eq({tag, " pc R7"}, {16'd0, cap_pc}, {16'd0, e_pc});
        chk_eq({tag, " cc"}, {24'd0, cap_cc}, {24'd0, e_cc});
        chk_eq({tag, " push count"}, pushes, 1);
        chk_eq({tag, " push width"}, {31'd0, last_full}, {31'd0, e_full});
        chk_eq({tag, " E at push R11"}, {31'd0, last_e}, {31'd0, e_full});
        chk_eq({tag, " reads R7"}, rd_cnt, 2);
        if (check_gap) chk_eq({tag, " delay R7"}, gap_seen, 4);
    endtask

    task automatic run_case(input logic [2:0] op, input logic [7:0] cc, input bit cfg,
                            input bit f, input bit n);
        bit e_vec, e_full, e_nmi;
        logic [15:0] e_pc;
        logic [7:0] e_cc;
        string tag;
        predict(exp_nmi, f, n, cfg, op, cc, e_vec, e_pc, e_cc, e_full, e_nmi, tag);
        start_op(op, cc, 8'hFF, cfg, f, n);
        wait_done();
        if (e_vec) check_vec(tag, e_pc, e_cc, e_full, 1'b1);
        else begin
            chk_eq({tag, " resume"}, {30'd0, got_ok, got_vec}, 32'd2);
            chk_eq({tag, " no push"}, pushes, 0);
            chk_eq({tag, " no read"}, rd_cnt, 0);
        end
        if (e_nmi) exp_nmi = 0;
    endtask

    // Mask-and-wait: decoy optional masked fast request, then wake (0 fast, 1 normal, 2 nmi).
    task automatic mw_case(input logic [7:0] cc, input logic [7:0] imm, input bit decoy,
                           input int wake, input logic [15:0] v, input logic [7:0] e_cc);
        start_op(3'd5, cc, imm, 1'b0, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        if (decoy) begin
            fast_line = 1'b1;
            repeat (10) @(negedge clk);
        end
        #1;
        chk_eq("R9 stalled busy", {31'd0, busy}, 32'd1);
        chk_eq("R9 single push before wake", pushes, 1);
        chk_eq("R9 no read while stalled", rd_cnt, 0);
        if (wake == 0) fast_line = 1'b1;
        else if (wake == 1) norm_line = 1'b1;
        else begin
            nmi_line = 1'b1; @(negedge clk); nmi_line = 1'b0;
        end
        wait_done();
        fast_line = 1'b0;
        check_vec("R10", {mem_byte(v), mem_byte(v + 16'd1)}, e_cc, 1'b1, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk_eq("R1 in reset", {26'd0, push_req, bus_rd, pc_load, cc_load, resume, busy}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk_eq("R1 after reset", {26'd0, push_req, bus_rd, pc_load, cc_load, resume, busy}, 32'd0);

        // Directed entries.
        nmi_pulse();
        run_case(3'd1, 8'h00, 1'b0, 1'b1, 1'b1);   // R2 R3 nmi beats all
        nmi_pulse();
        run_case(3'd2, 8'h7F, 1'b0, 1'b0, 1'b0);   // R3 nmi ignores masks
        run_case(3'd2, 8'h00, 1'b0, 1'b1, 1'b1);   // R4 fast partial
        run_case(3'd1, 8'h0F, 1'b1, 1'b1, 1'b0);   // R4 fast full
        run_case(3'd3, 8'h40, 1'b0, 1'b1, 1'b1);   // R2 R5 fast masked
        run_case(3'd1, 8'h2F, 1'b0, 1'b0, 1'b1);   // R5 F stays 0
        run_case(3'd1, 8'h01, 1'b0, 1'b0, 1'b0);   // R6 trap1
        run_case(3'd2, 8'h05, 1'b0, 1'b0, 1'b0);   // R6 trap2 masks unchanged
        run_case(3'd3, 8'h50, 1'b0, 1'b1, 1'b1);   // R6 trap3 with masked lines
        run_case(3'd4, 8'h10, 1'b0, 1'b0, 1'b1);   // R8 sync on masked normal

        // R8: sync stalls with nothing pending, resumes on a later fast request.
        start_op(3'd4, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0);
        begin
            int early = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (resume || pc_load || !busy) early++;
            end
            chk_eq("R8 stall without request", early, 0);
        end
        fast_line = 1'b1;
        wait_done();
        chk_eq("R8 resume after request", {30'd0, got_ok, got_vec}, 32'd2);
        chk_eq("R8 no push", pushes, 0);

        // Mask-and-wait cases (R9 R10).
        mw_case(8'h50, 8'hEF, 1'b1, 1, 16'hFFF8, 8'hD0);
        mw_case(8'h10, 8'hEF, 1'b0, 1, 16'hFFF8, 8'h90);
        mw_case(8'h00, 8'hFF, 1'b0, 0, 16'hFFF6, 8'hD0);
        mw_case(8'h53, 8'h0F, 1'b0, 2, 16'hFFFC, 8'hD3);
        run_case(3'd1, 8'h00, 1'b0, 1'b0, 1'b0);   // R10 latch was consumed: trap1 runs

        // Random mix.
        for (int k = 0; k < 40; k++) begin
            logic [7:0] cc = 8'($urandom);
            bit f = 1'($urandom);
            bit n = 1'($urandom);
            bit cfg = 1'($urandom);
            logic [2:0] op = 3'(1 + ($urandom % 4));
            if (($urandom % 5) == 0) nmi_pulse();
            if (op == 3'd4 && !f && !n && !exp_nmi) n = 1;
            run_case(op, cc, cfg, f, n);
        end
        finish_run();
    end

endmodule